// File: doc/BRIEF.md
# Byte FIFO Pair with Trigger Interrupts

This block holds the transmit and receive byte queues that sit between a register bus and a serial bus engine. Software fills the transmit queue through a data register and drains the receive queue through another. The serial engine, which is not part of this block, takes transmit bytes and delivers receive bytes through one-cycle strobes. Each queue has its own enable bit and its own programmable threshold. Each queue reports its fill level, a full flag and an empty flag.

Seven interrupt sources feed a sticky status word that software clears by writing ones. The sources are: transmit almost-empty, receive almost-full, an underrun and an overrun for each direction, and a trailing-data timeout. The trailing-data timeout fires when a few received bytes sit below the receive threshold and the engine has delivered nothing for a programmed number of clocks. It lets software collect a short tail without polling. An enable mask selects which status bits drive the single interrupt line.

The register bus uses a write strobe, a read strobe, a 3-bit word address and 32-bit data. Read data is combinational from the address. A read strobe on the receive data address removes the byte shown.

Top module: `dual_fifo_irq`

## Requirements
- R1: After reset both queues are disabled and empty, every status bit and every mask bit is 0, and `irq` is low.
- R2: The control register (address 0) holds receive enable in bit 0, transmit enable in bit 1, the receive threshold in bits 10:4 and the transmit threshold in bits 22:16. While a queue is disabled it is held empty, its pushes and pops are ignored and it raises no interrupt source.
- R3: The level word (address 4, read only) shows the transmit level in bits 6:0, transmit full in bit 7, transmit empty in bit 8, the receive level in bits 22:16, receive full in bit 23 and receive empty in bit 24. Bytes leave each queue in the order they entered.
- R4: A push to a full queue is dropped and leaves the contents unchanged. On the transmit side (bus write to address 5) it sets status bit 3. On the receive side (engine push) it sets status bit 5.
- R5: A pop from an empty queue returns the last byte removed from that queue (0 if none since reset). An engine pop sets status bit 2 (transmit underrun). A bus read with pop at address 6 sets status bit 4 (receive underrun).
- R6: Status bit 0 is set in every cycle in which the transmit queue is enabled and its level is at or below the transmit threshold.
- R7: Status bit 1 is set in every cycle in which the receive queue is enabled and its level is at or above the receive threshold.
- R8: The idle limit is at address 1, bits 7:0. An idle counter restarts on every receive push and runs only while the receive queue is non-empty and below its threshold. Status bit 6 is set exactly once, on the clock edge where the counter reaches the limit, which is the limit-th edge after the last push. A limit of 0 never sets it.
- R9: The status word (address 3) is sticky. Writing it clears the bits written as 1 and keeps the bits written as 0. A source active in the same cycle wins over the clear. Writing back a value just read clears every bit whose source is no longer active.
- R10: `irq` is high exactly while some status bit is 1 and its mask bit (address 2, bits 6:0) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe (removes a receive byte at address 6) |
| cfg_addr | input | 3 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from `cfg_addr` |
| eng_tx_pop | input | 1 | Engine takes the transmit head byte |
| eng_tx_data | output | 8 | Transmit head byte (last removed byte when empty) |
| eng_rx_push | input | 1 | Engine delivers a receive byte |
| eng_rx_data | input | 8 | Received byte |
| irq | output | 1 | Masked OR of the status word |

## Verification
The hardest condition to reach is the trailing-data timeout. It needs a receive queue that is non-empty and below threshold, a counter that restarts on each push, and a limit crossing that must fire exactly once. The stimulus pushes a single byte, watches the status bit on the edge before the limit and on the limit edge itself, and then clears the bit and waits to show that it does not return. It repeats this with a second push partway through the window to show the counter restarts, and with a limit of 0 to show the timeout stays off. Overrun and underrun are reached by filling a queue past its depth and by popping one byte past empty, with the scoreboard expecting the repeated last byte.

// File: rtl/dfq_pkg.sv
// Shared constants and types for the byte FIFO pair.
// Assumes a 3-bit word address and a 7-bit level field in the register view.
package dfq_pkg;
    localparam logic [2:0] ADR_CTRL  = 3'd0;
    localparam logic [2:0] ADR_TRAIL = 3'd1;
    localparam logic [2:0] ADR_IEN   = 3'd2;
    localparam logic [2:0] ADR_ISTAT = 3'd3;
    localparam logic [2:0] ADR_FSTAT = 3'd4;
    localparam logic [2:0] ADR_TXD   = 3'd5;
    localparam logic [2:0] ADR_RXD   = 3'd6;

    localparam int IRQ_N = 7;
    localparam int LVL_W = 7;

    localparam int IB_TX_AE  = 0;
    localparam int IB_RX_AF  = 1;
    localparam int IB_TX_UNF = 2;
    localparam int IB_TX_OVF = 3;
    localparam int IB_RX_UNF = 4;
    localparam int IB_RX_OVF = 5;
    localparam int IB_TRAIL  = 6;

    typedef struct packed {
        logic [LVL_W-1:0] tx_trig;
        logic [LVL_W-1:0] rx_trig;
        logic             tx_en;
        logic             rx_en;
    } fifo_ctrl_t;
endpackage

// File: rtl/dfq_byte_fifo.sv
// Synchronous byte queue with level, full/empty flags and error pulses.
// Assumes DEPTH is a power of two. Disabling holds the queue empty.
// A push when full is dropped. A pop when empty shows the last removed byte.
module dfq_byte_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] pop_data,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty,
    output logic          overrun,
    output logic          underrun
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic [LW-1:0] cnt;
    logic [DW-1:0] last_q;
    logic          do_push, do_pop;

    assign full     = (cnt == LW'(DEPTH));
    assign empty    = (cnt == '0);
    assign level    = cnt;
    assign do_push  = en && push && !full;
    assign do_pop   = en && pop && !empty;
    assign overrun  = en && push && full;
    assign underrun = en && pop && empty;
    assign pop_data = empty ? last_q : mem[rptr];

    // Pointer and occupancy tracking; cleared while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (do_push) wptr <= wptr + PW'(1);
            if (do_pop)  rptr <= rptr + PW'(1);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + LW'(1);
                2'b01:   cnt <= cnt - LW'(1);
                default: ;
            endcase
        end
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_data;
    end

    // Remembers the byte most recently removed, shown on underrun.
    always_ff @(posedge clk) begin
        if (!rst_n)      last_q <= '0;
        else if (do_pop) last_q <= mem[rptr];
    end

    assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && push && full && !pop) |=> full);
    assert_underrun_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && pop && empty && !push) |=> (pop_data == $past(pop_data)));
    assert_disable_empties_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> empty);
endmodule

// File: rtl/dfq_trail_timer.sv
// Idle timer for a partly filled receive queue.
// Restarts on each push and runs while the queue holds bytes below threshold.
// Pulses fire once on the edge where the count reaches the limit; limit 0 never fires.
module dfq_trail_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_push,
    input  logic          rx_empty,
    input  logic          below_trig,
    input  logic [CW-1:0] limit,
    output logic          fire
);
    logic [CW-1:0] cnt;
    logic          restart, running;

    assign restart = rx_push || rx_empty || !below_trig;
    assign running = !restart && (cnt < limit);
    assign fire    = running && ((cnt + CW'(1)) == limit);

    // Idle clock counter, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) cnt <= '0;
        else if (running)      cnt <= cnt + CW'(1);
    end

    assert_fire_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);
endmodule

// File: rtl/dfq_irq_ctrl.sv
// Sticky interrupt status, cleared by writing ones, masked into one line.
// A source active in the same cycle as a clear keeps its bit set.
module dfq_irq_ctrl #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         clr_we,
    input  logic [N-1:0] clr_mask,
    input  logic [N-1:0] en_mask,
    output logic [N-1:0] status,
    output logic         irq
);
    logic [N-1:0] clr_eff;

    assign clr_eff = clr_we ? clr_mask : '0;
    assign irq     = |(status & en_mask);

    // Status update: clear written ones, then merge new events.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_eff) | set;
    end

    for (genvar i = 0; i < N; i++) begin : g_chk
        assert_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we && clr_mask[i] && !set[i]) |=> !status[i]);
        assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (status[i] && !(clr_we && clr_mask[i])) |=> status[i]);
    end
endmodule

// File: rtl/dual_fifo_irq.sv
// Transmit and receive byte queues with a register view and interrupt logic.
// Assumes DEPTH is a power of two no larger than 64 (7-bit level field).
module dual_fifo_irq
    import dfq_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int TRAIL_W = 8,
    localparam int LW     = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic        cfg_rd,
    input  logic [2:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        eng_tx_pop,
    output logic [7:0]  eng_tx_data,
    input  logic        eng_rx_push,
    input  logic [7:0]  eng_rx_data,
    output logic        irq
);
    fifo_ctrl_t         ctrl_q;
    logic [TRAIL_W-1:0] trail_lim_q;
    logic [IRQ_N-1:0]   ien_q;
    logic [IRQ_N-1:0]   istat, isrc;
    logic [LW-1:0]      tx_lvl, rx_lvl;
    logic [LVL_W-1:0]   tx_lvl7, rx_lvl7;
    logic               tx_full, tx_empty, tx_ovf, tx_unf;
    logic               rx_full, rx_empty, rx_ovf, rx_unf;
    logic [7:0]         rx_head;
    logic               trail_fire;
    logic               unused_wbits;

    wire wr_ctrl  = cfg_wr && (cfg_addr == ADR_CTRL);
    wire wr_trail = cfg_wr && (cfg_addr == ADR_TRAIL);
    wire wr_ien   = cfg_wr && (cfg_addr == ADR_IEN);
    wire wr_istat = cfg_wr && (cfg_addr == ADR_ISTAT);
    wire wr_txd   = cfg_wr && (cfg_addr == ADR_TXD);
    wire rd_rxd   = cfg_rd && (cfg_addr == ADR_RXD);

    assign unused_wbits = ^{cfg_wdata[31:23], cfg_wdata[15:11], cfg_wdata[3:2]};

    // Configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q      <= '0;
            trail_lim_q <= '0;
            ien_q       <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.rx_en   <= cfg_wdata[0];
                ctrl_q.tx_en   <= cfg_wdata[1];
                ctrl_q.rx_trig <= cfg_wdata[10:4];
                ctrl_q.tx_trig <= cfg_wdata[22:16];
            end
            if (wr_trail) trail_lim_q <= cfg_wdata[TRAIL_W-1:0];
            if (wr_ien)   ien_q       <= cfg_wdata[IRQ_N-1:0];
        end
    end

    dfq_byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .en(ctrl_q.tx_en),
        .push(wr_txd), .push_data(cfg_wdata[7:0]),
        .pop(eng_tx_pop), .pop_data(eng_tx_data),
        .level(tx_lvl), .full(tx_full), .empty(tx_empty),
        .overrun(tx_ovf), .underrun(tx_unf)
    );

    dfq_byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .en(ctrl_q.rx_en),
        .push(eng_rx_push), .push_data(eng_rx_data),
        .pop(rd_rxd), .pop_data(rx_head),
        .level(rx_lvl), .full(rx_full), .empty(rx_empty),
        .overrun(rx_ovf), .underrun(rx_unf)
    );

    assign tx_lvl7 = LVL_W'(tx_lvl);
    assign rx_lvl7 = LVL_W'(rx_lvl);

    dfq_trail_timer #(.CW(TRAIL_W)) u_trail (
        .clk(clk), .rst_n(rst_n),
        .rx_push(ctrl_q.rx_en && eng_rx_push),
        .rx_empty(rx_empty),
        .below_trig(rx_lvl7 < ctrl_q.rx_trig),
        .limit(trail_lim_q),
        .fire(trail_fire)
    );

    // Interrupt sources gathered into status bit positions.
    always_comb begin
        isrc            = '0;
        isrc[IB_TX_AE]  = ctrl_q.tx_en && (tx_lvl7 <= ctrl_q.tx_trig);
        isrc[IB_RX_AF]  = ctrl_q.rx_en && (rx_lvl7 >= ctrl_q.rx_trig);
        isrc[IB_TX_UNF] = tx_unf;
        isrc[IB_TX_OVF] = tx_ovf;
        isrc[IB_RX_UNF] = rx_unf;
        isrc[IB_RX_OVF] = rx_ovf;
        isrc[IB_TRAIL]  = trail_fire;
    end

    dfq_irq_ctrl #(.N(IRQ_N)) u_irq (
        .clk(clk), .rst_n(rst_n), .set(isrc),
        .clr_we(wr_istat), .clr_mask(cfg_wdata[IRQ_N-1:0]),
        .en_mask(ien_q), .status(istat), .irq(irq)
    );

    // Register read view selected by address.
    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            ADR_CTRL: begin
                cfg_rdata[0]     = ctrl_q.rx_en;
                cfg_rdata[1]     = ctrl_q.tx_en;
                cfg_rdata[10:4]  = ctrl_q.rx_trig;
                cfg_rdata[22:16] = ctrl_q.tx_trig;
            end
            ADR_TRAIL: cfg_rdata[TRAIL_W-1:0] = trail_lim_q;
            ADR_IEN:   cfg_rdata[IRQ_N-1:0]   = ien_q;
            ADR_ISTAT: cfg_rdata[IRQ_N-1:0]   = istat;
            ADR_FSTAT: begin
                cfg_rdata[6:0]   = tx_lvl7;
                cfg_rdata[7]     = tx_full;
                cfg_rdata[8]     = tx_empty;
                cfg_rdata[22:16] = rx_lvl7;
                cfg_rdata[23]    = rx_full;
                cfg_rdata[24]    = rx_empty;
            end
            ADR_RXD:   cfg_rdata[7:0] = rx_head;
            default:   ;
        endcase
    end

    assert_tx_almost_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.tx_en && (tx_lvl7 <= ctrl_q.tx_trig)) |=> istat[IB_TX_AE]);
    assert_rx_almost_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.rx_en && (rx_lvl7 >= ctrl_q.rx_trig)) |=> istat[IB_RX_AF]);
endmodule

// File: tb/test_dual_fifo_irq.sv
`timescale 1ns/1ps
module test_dual_fifo_irq;
    localparam int DEPTH = 16;
    localparam logic [2:0] A_CTRL = 3'd0, A_TRL = 3'd1, A_IEN = 3'd2, A_IST = 3'd3,
                           A_FST = 3'd4, A_TXD = 3'd5, A_RXD = 3'd6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        eng_tx_pop = 1'b0;
    logic [7:0]  eng_tx_data;
    logic        eng_rx_push = 1'b0;
    logic [7:0]  eng_rx_data = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [7:0] txq[$];
    logic [7:0] rxq[$];
    logic [7:0] tx_last = '0;
    logic [7:0] rx_last = '0;
    logic [31:0] v;

    always #2.5 clk = ~clk;

    dual_fifo_irq #(.DEPTH(DEPTH), .TRAIL_W(8)) i_dual_fifo_irq (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
        .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    // Driver: bus write into the transmit queue, queued when expected to land.
    task automatic tx_send(input logic [7:0] b, input bit accepted);
        wr(A_TXD, {24'h0, b});
        if (accepted) txq.push_back(b);
    endtask

    task automatic tx_take();
        @(negedge clk); eng_tx_pop = 1'b1;
        @(negedge clk); eng_tx_pop = 1'b0;
    endtask

    // Driver: engine delivers a receive byte.
    task automatic rx_send(input logic [7:0] b, input bit accepted);
        @(negedge clk); eng_rx_push = 1'b1; eng_rx_data = b;
        @(negedge clk); eng_rx_push = 1'b0;
        if (accepted) rxq.push_back(b);
    endtask

    task automatic rx_take();
        @(negedge clk); cfg_addr = A_RXD; cfg_rd = 1'b1;
        @(negedge clk); cfg_rd = 1'b0;
    endtask

    // Monitor: compares every transmit pop against the scoreboard (R3 or R5).
    always @(negedge clk) begin
        #1;
        if (eng_tx_pop) begin
            logic [7:0] e;
            e = (txq.size() > 0) ? txq.pop_front() : tx_last;
            tx_last = e;
            chk("R3 or R5 tx byte", {24'h0, eng_tx_data}, {24'h0, e});
        end
    end

    // Monitor: compares every receive read against the scoreboard (R3 or R5).
    always @(negedge clk) begin
        #1;
        if (cfg_rd && cfg_addr == A_RXD) begin
            logic [7:0] e;
            e = (rxq.size() > 0) ? rxq.pop_front() : rx_last;
            rx_last = e;
            chk("R3 or R5 rx byte", {24'h0, cfg_rdata[7:0]}, {24'h0, e});
        end
    end

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_FST, v);  chk("R1 level word", v, 32'h0100_0100);
        rd(A_IST, v);  chk("R1 status", v, 32'h0);
        rd(A_CTRL, v); chk("R1 control", v, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);

        // R2 disabled queue ignores pushes
        tx_send(8'hAA, 1'b0);
        rd(A_FST, v); chk("R2 disabled push ignored", v, 32'h0100_0100);
        rd(A_IST, v); chk("R2 no source while disabled", v, 32'h0);

        // R2 enable, rx threshold 4, tx threshold 2
        wr(A_CTRL, 32'h0002_0043);
        rd(A_CTRL, v); chk("R2 control fields", v, 32'h0002_0043);
        rd(A_IST, v);  chk("R6 almost-empty at level 0", v, 32'h1);

        for (int i = 0; i < 5; i++) tx_send(8'h11 + 8'(i), 1'b1);
        rd(A_FST, v); chk("R3 tx level 5", v, 32'h0100_0005);
        wr(A_IST, 32'h1);
        rd(A_IST, v); chk("R9 clear above threshold", v, 32'h0);
        for (int i = 0; i < 3; i++) tx_take();
        rd(A_IST, v); chk("R6 almost-empty at level 2", v, 32'h1);
        tx_take(); tx_take();
        tx_take();
        rd(A_IST, v); chk("R5 tx underrun bit 2", v, 32'h5);

        // R4 transmit overrun
        wr(A_IST, 32'h7F);
        for (int i = 0; i < DEPTH; i++) tx_send(8'h40 + 8'(i), 1'b1);
        tx_send(8'hEE, 1'b0);
        rd(A_FST, v); chk("R4 tx full level", v, 32'h0100_0090);
        rd(A_IST, v); chk("R4 tx overrun bit 3", v, 32'h9);

        // R10 mask
        wr(A_IEN, 32'h8);
        chk("R10 irq masked-in", {31'h0, irq}, 32'h1);
        wr(A_IEN, 32'h10);
        chk("R10 irq masked-out", {31'h0, irq}, 32'h0);
        for (int i = 0; i < DEPTH; i++) tx_take();

        // R9 write back of read value
        rd(A_IST, v); wr(A_IST, v);
        rd(A_IST, v); chk("R9 write-back clears", v, 32'h1);

        // R7 receive almost-full
        for (int i = 0; i < 3; i++) rx_send(8'h21 + 8'(i), 1'b1);
        rd(A_IST, v); chk("R7 below threshold", v, 32'h1);
        rd(A_FST, v); chk("R3 rx level 3", v, 32'h0003_0100);
        rx_send(8'h24, 1'b1);
        rd(A_IST, v); chk("R7 at threshold", v, 32'h3);
        for (int i = 0; i < 4; i++) rx_take();
        rx_take();
        rd(A_IST, v); chk("R5 rx underrun bit 4", v, 32'h13);

        // R4 receive overrun
        wr(A_IST, 32'h7F);
        rd(A_IST, v); chk("R9 cleared", v, 32'h1);
        for (int i = 0; i < DEPTH; i++) rx_send(8'h50 + 8'(i), 1'b1);
        rx_send(8'hEF, 1'b0);
        rd(A_FST, v); chk("R4 rx full level", v, 32'h0090_0100);
        rd(A_IST, v); chk("R4 rx overrun bit 5", v, 32'h23);
        for (int i = 0; i < DEPTH; i++) rx_take();
        wr(A_IST, 32'h7F);

        // R8 trailing timeout, limit 6
        wr(A_TRL, 32'h6);
        wr(A_IEN, 32'h40);
        rx_send(8'h77, 1'b1);
        cfg_addr = A_IST;
        repeat (5) @(negedge clk);
        #1 chk("R8 not before limit", {31'h0, cfg_rdata[6]}, 32'h0);
        chk("R10 irq before limit", {31'h0, irq}, 32'h0);
        @(negedge clk);
        #1 chk("R8 fires at limit", {31'h0, cfg_rdata[6]}, 32'h1);
        chk("R10 irq at limit", {31'h0, irq}, 32'h1);
        wr(A_IST, 32'h40);
        repeat (12) @(negedge clk);
        rd(A_IST, v); chk("R8 fires once", {31'h0, v[6]}, 32'h0);

        // R8 second push restarts the count (queue now holds 2)
        rx_send(8'h78, 1'b1);
        cfg_addr = A_IST;
        repeat (5) @(negedge clk);
        #1 chk("R8 restart before limit", {31'h0, cfg_rdata[6]}, 32'h0);
        @(negedge clk);
        #1 chk("R8 restart fires at limit", {31'h0, cfg_rdata[6]}, 32'h1);
        rx_take(); rx_take();

        // R8 limit zero disables
        wr(A_TRL, 32'h0);
        wr(A_IST, 32'h7F);
        rx_send(8'h79, 1'b1);
        repeat (20) @(negedge clk);
        rd(A_IST, v); chk("R8 limit zero silent", {31'h0, v[6]}, 32'h0);
        rx_take();

        // R2 disabling flushes stored bytes
        rx_send(8'h90, 1'b0);
        rx_send(8'h91, 1'b0);
        wr(A_CTRL, 32'h0002_0042);
        rd(A_FST, v); chk("R2 disable flushes rx", v, 32'h0100_0100);

        report();
    end
endmodule